// File: doc/BRIEF.md
# Newton Reciprocal Iteration Unit

This unit computes the reciprocal of a normalized fixed-point divisor `B` with 0.5 ≤ B < 1. The reciprocal then lies in the range 1 < 1/B ≤ 2. The unit also forms a quotient by multiplying a fractional dividend by that reciprocal. Every value uses an unsigned format with 2 integer bits and 16 fraction bits (Q2.16). Each product is truncated back to that width by dropping its 16 lowest bits.

A start pulse loads the divisor, the dividend and a tolerance. The unit then takes a first estimate from a small table indexed by the divisor's top bits. It improves that estimate with the Newton step X' = X·(2 − B·X), using one shared multiplier. Each step therefore costs two multiply cycles. Refinement ends at the first estimate whose residual 1 − B·X is at or below the tolerance, or after four updates, whichever comes first. One more multiply then forms the quotient, and a one-cycle `done` pulse marks both results as valid.

Top module: `nr_recip_unit`

## Requirements
- R1: After reset, `recip`, `quot` and `done` are all zero.
- R2: The first estimate is floor(2^20 / (9 + k)), where k is divisor bits [14:12] (the three bits below the leading one at bit 15), unless `seed_one` selects 1.0 (0x10000). When `tol` is all ones, `recip` equals that first estimate.
- R3: One update computes a = trunc(B·X), then X' = trunc(X·(2.0 − a)). Here trunc keeps bits [33:16] of the 36-bit product, and 2.0 is 0x20000. Every reported reciprocal lies in [1.0, 2.0].
- R4: For each estimate, the residual is 0x10000 − a, or 0 when a ≥ 0x10000. Refinement ends at the first estimate whose residual is ≤ `tol`.
- R5: At most four updates are applied. After the fourth, the estimate is reported even if the residual still exceeds `tol`.
- R6: `quot` equals trunc(A·X_final), where A is the 16-bit fractional `dividend` read as Q0.16.
- R7: With `seed_one` = 1 and B = 0.75 (0x0C000), stopping after one to four updates yields 0x14000, 0x15400, 0x15554 and 0x15555.
- R8: `done` is high for exactly one cycle. It rises 2n+3 clock edges after the edge that samples `start`, counting that edge as the first, where n is the number of updates applied.
- R9: A `start` asserted while an operation is in progress is ignored, and the running operation completes with its own operands.
- R10: `recip` and `quot` hold their values from one `done` to the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| seed_one | input | 1 | Use 1.0 as the first estimate instead of the table |
| divisor | input | 18 | B in Q2.16, must satisfy 0.5 ≤ B < 1 |
| dividend | input | 16 | A as an unsigned Q0.16 fraction |
| tol | input | 18 | Residual tolerance in Q2.16 |
| recip | output | 18 | Final reciprocal estimate, Q2.16 |
| quot | output | 18 | A times the reciprocal, Q2.16 |
| done | output | 1 | One-cycle pulse when results are valid |

## Verification
The assertions take for granted that the divisor is normalized, with bits 17 and 16 clear and bit 15 set. Only then does every estimate stay between 1.0 and 1/B, which keeps the range check valid. The stimulus sweeps divisors only from 0x08000 to 0x0FFFF, in strides and at each table boundary. It raises `start` only while the unit is idle, except in the case that deliberately targets the ignored-start rule. It varies the dividend and the tolerance independently of each other.

// File: rtl/nr_pkg.sv
package nr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PROD = 2'd1,
        ST_UPD  = 2'd2,
        ST_QUOT = 2'd3
    } nr_state_e;

    // Table entry k: reciprocal of the upper end of the k-th divisor interval
    function automatic longint seed_value(input int fw, input int idxw, input int k);
        return (longint'(1) << (fw + idxw + 1)) / longint'((1 << idxw) + 1 + k);
    endfunction

endpackage

// File: rtl/nr_seed_rom.sv
module nr_seed_rom #(
    parameter int FW   = 16,
    parameter int IDXW = 3,
    parameter int W    = 18
) (
    input  logic [IDXW-1:0] idx,
    output logic [W-1:0]    seed
);
    localparam int ENTRIES = 1 << IDXW;

    logic [W-1:0] table_w [ENTRIES];

    for (genvar k = 0; k < ENTRIES; k++) begin : g_entry
        localparam logic [W-1:0] VAL = W'(nr_pkg::seed_value(FW, IDXW, k));
        assign table_w[k] = VAL;
    end

    assign seed = table_w[idx];
endmodule

// File: rtl/nr_mul.sv
module nr_mul #(
    parameter int FW = 16,
    parameter int W  = 18
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] prod
);
    logic [2*W-1:0] full_w;

    assign full_w = {{W{1'b0}}, op_a} * {{W{1'b0}}, op_b};
    assign prod   = W'(full_w >> FW);
endmodule

// File: rtl/nr_recip_unit.sv
module nr_recip_unit #(
    parameter int IW    = 2,
    parameter int FW    = 16,
    parameter int IDXW  = 3,
    parameter int MAXIT = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 seed_one,
    input  logic [IW+FW-1:0]     divisor,
    input  logic [FW-1:0]        dividend,
    input  logic [IW+FW-1:0]     tol,
    output logic [IW+FW-1:0]     recip,
    output logic [IW+FW-1:0]     quot,
    output logic                 done
);
    import nr_pkg::*;

    localparam int W   = IW + FW;
    localparam int ITW = $clog2(MAXIT + 1);
    localparam logic [W-1:0]   ONE   = W'(1) << FW;
    localparam logic [W-1:0]   TWO   = W'(2) << FW;
    localparam logic [ITW-1:0] ITCAP = ITW'(MAXIT);

    typedef struct packed {
        nr_state_e      state;
        logic [W-1:0]   b;
        logic [FW-1:0]  dvd;
        logic [W-1:0]   eps;
        logic [W-1:0]   x;
        logic [W-1:0]   amul;
        logic [ITW-1:0] iter;
        logic [W-1:0]   recip;
        logic [W-1:0]   quot;
        logic           done;
    } nr_regs_t;

    nr_regs_t r_q, r_d;

    logic [W-1:0] seed_w;
    logic [W-1:0] op_a, op_b, prod;
    logic [W-1:0] resid;

    nr_seed_rom #(.FW(FW), .IDXW(IDXW), .W(W)) u_seed (
        .idx  (divisor[FW-2 -: IDXW]),
        .seed (seed_w)
    );

    // Single multiplier shared by all three product kinds
    always_comb begin
        case (r_q.state)
            ST_UPD: begin
                op_a = r_q.x;
                op_b = TWO - r_q.amul;
            end
            ST_QUOT: begin
                op_a = {{IW{1'b0}}, r_q.dvd};
                op_b = r_q.x;
            end
            default: begin
                op_a = r_q.b;
                op_b = r_q.x;
            end
        endcase
    end

    nr_mul #(.FW(FW), .W(W)) u_mul (
        .op_a (op_a),
        .op_b (op_b),
        .prod (prod)
    );

    assign resid = (prod >= ONE) ? '0 : ONE - prod;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.b     = divisor;
                    r_d.dvd   = dividend;
                    r_d.eps   = tol;
                    r_d.x     = seed_one ? ONE : seed_w;
                    r_d.iter  = '0;
                    r_d.state = ST_PROD;
                end
            end
            ST_PROD: begin
                if (resid <= r_q.eps || r_q.iter == ITCAP) begin
                    r_d.state = ST_QUOT;
                end else begin
                    r_d.amul  = prod;
                    r_d.state = ST_UPD;
                end
            end
            ST_UPD: begin
                r_d.x     = prod;
                r_d.iter  = r_q.iter + ITW'(1);
                r_d.state = ST_PROD;
            end
            ST_QUOT: begin
                r_d.quot  = prod;
                r_d.recip = r_q.x;
                r_d.done  = 1'b1;
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign recip = r_q.recip;
    assign quot  = r_q.quot;
    assign done  = r_q.done;
endmodule

// File: rtl/nr_recip_chk.sv
module nr_recip_chk #(
    parameter int W     = 18,
    parameter int FW    = 16,
    parameter int ITW   = 3,
    parameter int MAXIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              done,
    input  logic [W-1:0]      recip,
    input  logic [W-1:0]      quot,
    input  nr_pkg::nr_state_e state,
    input  logic [ITW-1:0]    iter,
    input  logic [W-1:0]      b_q,
    input  logic [W-1:0]      resid,
    input  logic [W-1:0]      eps_q
);
    import nr_pkg::*;

    localparam logic [W-1:0]   ONE   = W'(1) << FW;
    localparam logic [W-1:0]   TWO   = W'(2) << FW;
    localparam logic [ITW-1:0] ITCAP = ITW'(MAXIT);

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_iter_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPD) |-> (iter < ITCAP));

    assert_stop_rule_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPD) |-> ($past(resid) > $past(eps_q)));

    assert_recip_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (recip >= ONE && recip <= TWO));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> ($stable(recip) && $stable(quot)));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> $stable(b_q));
endmodule

bind nr_recip_unit nr_recip_chk #(
    .W(IW + FW), .FW(FW), .ITW($clog2(MAXIT + 1)), .MAXIT(MAXIT)
) u_nr_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .done  (done),
    .recip (recip),
    .quot  (quot),
    .state (r_q.state),
    .iter  (r_q.iter),
    .b_q   (r_q.b),
    .resid (resid),
    .eps_q (r_q.eps)
);

// File: tb/test_nr_recip_unit.sv
module test_nr_recip_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        seed_one = 1'b0;
    logic [17:0] divisor = '0;
    logic [15:0] dividend = '0;
    logic [17:0] tol = '0;
    logic [17:0] recip, quot;
    logic        done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc++;

    nr_recip_unit i_nr_recip_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .seed_one(seed_one),
        .divisor(divisor), .dividend(dividend), .tol(tol),
        .recip(recip), .quot(quot), .done(done)
    );

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Arithmetic model of the requirements
    task automatic model(input longint b, input longint a, input longint e, input bit s1,
                         output longint x, output longint q, output int n);
        longint p, r;
        x = s1 ? 65536 : (longint'(1) << 20) / (9 + ((b >> 12) & 7));
        n = 0;
        forever begin
            p = ((b * x) >> 16) & 18'h3FFFF;
            r = (p >= 65536) ? 0 : 65536 - p;
            if (r <= e || n == 4) break;
            x = ((x * (131072 - p)) >> 16) & 18'h3FFFF;
            n++;
        end
        q = ((a * x) >> 16) & 18'h3FFFF;
    endtask

    task automatic run(input logic [17:0] b, input logic [15:0] a, input logic [17:0] e,
                       input bit s1, input bit poke, output int lat);
        lat = 0;
        @(negedge clk);
        divisor = b; dividend = a; tol = e; seed_one = s1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            if (poke && lat == 2) begin
                start = 1'b1; divisor = 18'h08000; dividend = 16'hFFFF; tol = 18'h3FFFF;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        start = 1'b0;
        if (!done) begin
            errors++;
            $display("FAIL R8 actual=no done expected=done within 100 cycles");
        end
    endtask

    task automatic full_check(input logic [17:0] b, input logic [15:0] a, input logic [17:0] e,
                              input bit s1);
        longint xe, qe;
        int ne, lat;
        model(b, a, e, s1, xe, qe, ne);
        run(b, a, e, s1, 1'b0, lat);
        check("R3/R4/R5 recip", recip, xe);
        check("R6 quot", quot, qe);
        check("R8 latency", lat, 2 * ne + 3);
        @(negedge clk);
        check("R8 done one cycle", done, 0);
    endtask

    initial begin
        int lat;
        longint xe, qe;
        int ne;
        logic [17:0] keep_r, keep_q;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 recip", recip, 0);
        check("R1 quot", quot, 0);
        check("R1 done", done, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 each table entry, stop immediately
        for (int k = 0; k < 8; k++) begin
            run(18'(32768 + k * 4096 + 5), 16'h8000, 18'h3FFFF, 1'b0, 1'b0, lat);
            check("R2 seed", recip, (longint'(1) << 20) / (9 + k));
            check("R8 latency n=0", lat, 3);
        end
        run(18'h0C000, 16'h8000, 18'h3FFFF, 1'b1, 1'b0, lat);
        check("R2 unit seed", recip, 65536);

        // R7 unit seed, B = 0.75, stop after 1..4 updates
        run(18'h0C000, 16'h0000, 18'd16383, 1'b1, 1'b0, lat);
        check("R7 X1", recip, 18'h14000);
        check("R8 latency n=1", lat, 5);
        run(18'h0C000, 16'h0000, 18'd4095, 1'b1, 1'b0, lat);
        check("R7 X2", recip, 18'h15400);
        run(18'h0C000, 16'h0000, 18'd255, 1'b1, 1'b0, lat);
        check("R7 X3", recip, 18'h15554);
        run(18'h0C000, 16'hC000, 18'd0, 1'b1, 1'b0, lat);
        check("R7 X4", recip, 18'h15555);
        check("R5 capped latency", lat, 11);
        check("R6 quot 0.75*X4", quot, (longint'(16'hC000) * 18'h15555) >> 16);

        // R10 hold while idle with changing inputs
        keep_r = recip; keep_q = quot;
        divisor = 18'h09000; dividend = 16'h1234; tol = 18'd7;
        repeat (5) @(negedge clk);
        check("R10 recip hold", recip, keep_r);
        check("R10 quot hold", quot, keep_q);

        // R9 start during a run is ignored
        model(18'h0E123, 16'h5A5A, 18'd0, 1'b0, xe, qe, ne);
        run(18'h0E123, 16'h5A5A, 18'd0, 1'b0, 1'b1, lat);
        check("R9 recip", recip, xe);
        check("R9 quot", quot, qe);
        check("R9 latency", lat, 2 * ne + 3);

        // Sweep over divisors, tolerances and seed modes
        for (int v = 32768; v < 65536; v += 61) begin
            logic [17:0] e;
            case (v % 6)
                0: e = 18'd0;
                1: e = 18'd1;
                2: e = 18'd16;
                3: e = 18'd256;
                4: e = 18'd4096;
                default: e = 18'h3FFFF;
            endcase
            full_check(18'(v), 16'((v * 7919) & 16'hFFFF), e, (v % 3) == 0);
        end
        full_check(18'h0FFFF, 16'hFFFF, 18'd0, 1'b0);
        full_check(18'h08000, 16'hFFFF, 18'd0, 1'b0);
        full_check(18'h08000, 16'hFFFF, 18'd0, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc >= 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule